// File: doc/BRIEF.md
# Cache-Block Bundled Branch Target Buffer

This block supplies branch targets to an instruction fetch unit. Its storage is organised around instruction-cache blocks rather than around individual branches. Every cache block of 64 bytes, which is 16 four-byte instruction slots, owns one bundle. A bundle records a 16-bit map of which slots hold branches and a small number of branch entries. Each entry holds a slot offset, a 2-bit kind and a 30-bit target. The fetch unit installs or drops a bundle in the same cycle that the instruction cache fills or evicts the block, so the two structures stay in step.

On a lookup the block takes the word address of the fetch, picks the bundle of that block and scans its branch map upward from the fetch slot. It takes the lowest marked slot and looks for that slot's entry, first among the bundle's own entries and then in a small fully associative overflow store. That store holds the branches a fill could not fit into the bundle. The answer comes back one cycle later as registered outputs: a hit flag, the kind and target, and the next fetch word address. When no branch is found, the next fetch word address is the first word of the following block. All addresses at the ports are word addresses; the byte address is the word address times four.

Top module: `bundle_btb`

## Requirements
- R1: After reset, `lk_vld` is 0 and every bundle is empty, so any lookup reports `lk_hit`=0 with a fall-through next address.
- R2: `lk_vld` is 1 in exactly the cycle after a cycle with `lk_en`=1, and 0 otherwise. The result fields are registered.
- R3: If the bundle is present and a marked slot exists at or above the fetch slot (`lk_word[3:0]`), the lowest such slot is chosen. When its entry exists, the block reports `lk_hit`=1, the entry's kind and target, and `lk_next` equal to the target. A marked slot equal to the fetch slot counts.
- R4: If no marked slot lies at or above the fetch slot, the block reports `lk_hit`=0, `lk_kind`=0 and `lk_target`=0. `lk_next` is `{lk_word[29:4]+1, 4'b0000}`.
- R5: A fill carries up to four branches in `fill_off`/`fill_kind`/`fill_tgt` slices 0 to 3, with `fill_num` of them valid. Slices 0 to 2 become bundle entries, and slice 3 goes to the overflow store when `fill_num`=4. A lookup whose chosen slot is held only in the overflow store still hits with that entry's kind and target.
- R6: A fill replaces the whole bundle at its index and invalidates every overflow entry of the same block. Branches from an earlier fill of that block are no longer reported.
- R7: An eviction whose block matches the stored bundle clears that bundle and invalidates the block's overflow entries. Later lookups of the block report `lk_hit`=0 with fall-through.
- R8: The overflow store is written in round-robin order, one slot per overflow write. An overflow entry survives exactly OVF_DEPTH-1 later overflow writes and is replaced by the next one.
- R9: The bundle index is the block address modulo NUM_BUNDLES. A lookup of a different block that maps to the same index reports `lk_hit`=0 with fall-through.
- R10: If the chosen slot has no entry in the bundle or the overflow store, the block reports `lk_hit`=0 with fall-through. It does not move on to a later slot.
- R11: When a fill and an eviction target the same index in one cycle, the fill wins and the bundle stays present.
- R12: A lookup sees the storage as it was before the clock edge. A fill in the same cycle only affects later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup request |
| lk_word | input | 30 | Fetch word address; bits 3:0 are the slot |
| fill_en | input | 1 | Install a bundle |
| fill_blk | input | 26 | Block address being installed |
| fill_map | input | 16 | Branch slot map of the block; bit n is slot n |
| fill_num | input | 3 | Number of valid branch slices (0 to 4) |
| fill_off | input | 16 | Slot offset of slice n at bits 4n+3:4n |
| fill_kind | input | 8 | Kind of slice n at bits 2n+1:2n |
| fill_tgt | input | 120 | Target word address of slice n at bits 30n+29:30n |
| evict_en | input | 1 | Drop a bundle |
| evict_blk | input | 26 | Block address being dropped |
| lk_vld | output | 1 | Lookup result valid |
| lk_hit | output | 1 | A branch entry was found |
| lk_kind | output | 2 | Branch kind, 0 when no hit |
| lk_target | output | 30 | Branch target word address, 0 when no hit |
| lk_next | output | 30 | Next fetch word address |

## Verification
The bench targets four kinds of fault. A scan that starts one slot too high misses a branch sitting exactly at the fetch slot. A design that prefers the overflow store, or skips it, returns the wrong kind or misses the fourth branch of a dense block. A fill that does not purge the old overflow entries lets a stale branch reappear after a refill. A round-robin pointer that is off by one drops the entry a cycle early or late. Aliased blocks at one index, a marked slot whose entry was lost, a fill that collides with an eviction, and a lookup issued in the same cycle as its own fill are each driven. A wrong design would show up as a spurious hit or a wrong next address.

// File: rtl/bbtb_pkg.sv
package bbtb_pkg;
  localparam int SLOTS  = 16;
  localparam int OFF_W  = 4;
  localparam int KIND_W = 2;
  localparam int WA_W   = 30;
  localparam int BLK_W  = WA_W - OFF_W;

  typedef enum logic [KIND_W-1:0] {
    K_COND = 2'd0,
    K_JUMP = 2'd1,
    K_CALL = 2'd2,
    K_RET  = 2'd3
  } br_kind_e;

  typedef struct packed {
    logic              vld;
    logic [OFF_W-1:0]  off;
    logic [KIND_W-1:0] kind;
    logic [WA_W-1:0]   tgt;
  } br_ent_t;

  typedef struct packed {
    logic              vld;
    logic [BLK_W-1:0]  blk;
    logic [OFF_W-1:0]  off;
    logic [KIND_W-1:0] kind;
    logic [WA_W-1:0]   tgt;
  } ovf_ent_t;

  // slots at or above the fetch slot
  function automatic logic [SLOTS-1:0] slots_from(input logic [OFF_W-1:0] off);
    return {SLOTS{1'b1}} << off;
  endfunction

  // {found, index of lowest set bit}
  function automatic logic [OFF_W:0] first_set(input logic [SLOTS-1:0] v);
    logic [OFF_W:0] r;
    r = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, OFF_W'(i)};
    end
    return r;
  endfunction

  function automatic logic [WA_W-1:0] next_block_word(input logic [BLK_W-1:0] blk);
    return {blk + BLK_W'(1), {OFF_W{1'b0}}};
  endfunction
endpackage

// File: rtl/bbtb_bundle_array.sv
module bbtb_bundle_array
  import bbtb_pkg::*;
#(
  parameter int NB  = 16,
  parameter int ENT = 3,
  localparam int IDX_W = $clog2(NB),
  localparam int TAG_W = BLK_W - IDX_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [BLK_W-1:0] fill_blk,
  input  logic [SLOTS-1:0] fill_map,
  input  br_ent_t          fill_ents [ENT],
  input  logic             evict_en,
  input  logic [BLK_W-1:0] evict_blk,
  input  logic [BLK_W-1:0] rd_blk,
  output logic             rd_present,
  output logic [SLOTS-1:0] rd_map,
  output br_ent_t          rd_ents [ENT]
);
  logic [NB-1:0]    vld_q;
  logic [TAG_W-1:0] tag_q [NB];
  logic [SLOTS-1:0] map_q [NB];
  br_ent_t          ent_q [NB][ENT];

  logic [IDX_W-1:0] fill_idx, ev_idx, rd_idx;
  logic             evict_apply;

  assign fill_idx = fill_blk[IDX_W-1:0];
  assign ev_idx   = evict_blk[IDX_W-1:0];
  assign rd_idx   = rd_blk[IDX_W-1:0];

  // eviction only of the block actually held; a fill to the same index wins
  assign evict_apply = evict_en && vld_q[ev_idx] &&
                       (tag_q[ev_idx] == evict_blk[BLK_W-1:IDX_W]) &&
                       !(fill_en && (fill_idx == ev_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (evict_apply) vld_q[ev_idx] <= 1'b0;
      if (fill_en)     vld_q[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx] <= fill_blk[BLK_W-1:IDX_W];
      map_q[fill_idx] <= fill_map;
      for (int g = 0; g < ENT; g++) ent_q[fill_idx][g] <= fill_ents[g];
    end
  end

  assign rd_present = vld_q[rd_idx] && (tag_q[rd_idx] == rd_blk[BLK_W-1:IDX_W]);
  assign rd_map     = map_q[rd_idx];

  always_comb begin
    for (int g = 0; g < ENT; g++) rd_ents[g] = ent_q[rd_idx][g];
  end
endmodule

// File: rtl/bbtb_overflow.sv
module bbtb_overflow
  import bbtb_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [KIND_W-1:0] wr_kind,
  input  logic [WA_W-1:0]   wr_tgt,
  input  logic              kill_a_en,
  input  logic [BLK_W-1:0]  kill_a_blk,
  input  logic              kill_b_en,
  input  logic [BLK_W-1:0]  kill_b_blk,
  input  logic [BLK_W-1:0]  rd_blk,
  input  logic [OFF_W-1:0]  rd_off,
  output logic              rd_hit,
  output logic [KIND_W-1:0] rd_kind,
  output logic [WA_W-1:0]   rd_tgt,
  output logic [DEPTH-1:0]  hit_vec,
  output logic [PTR_W-1:0]  ptr
);
  ovf_ent_t         ent_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      ptr_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ent_q[i].vld &&
            ((kill_a_en && ent_q[i].blk == kill_a_blk) ||
             (kill_b_en && ent_q[i].blk == kill_b_blk)))
          ent_q[i].vld <= 1'b0;
      end
      if (wr_en) begin
        ent_q[ptr_q] <= {1'b1, wr_blk, wr_off, wr_kind, wr_tgt};
        ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + PTR_W'(1);
      end
    end
  end

  assign ptr = ptr_q;

  always_comb begin
    rd_kind = '0;
    rd_tgt  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_vec[i] = ent_q[i].vld && (ent_q[i].blk == rd_blk) && (ent_q[i].off == rd_off);
      rd_kind    = rd_kind | (ent_q[i].kind & {KIND_W{hit_vec[i]}});
      rd_tgt     = rd_tgt  | (ent_q[i].tgt  & {WA_W{hit_vec[i]}});
    end
    rd_hit = |hit_vec;
  end
endmodule

// File: rtl/bundle_btb.sv
module bundle_btb
  import bbtb_pkg::*;
#(
  parameter int NUM_BUNDLES   = 16,
  parameter int BR_PER_BUNDLE = 3,
  parameter int OVF_DEPTH     = 32,
  localparam int FILL_BR = BR_PER_BUNDLE + 1,
  localparam int NUM_W   = $clog2(FILL_BR + 1),
  localparam int PTR_W   = $clog2(OVF_DEPTH)
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lk_en,
  input  logic [WA_W-1:0]           lk_word,
  input  logic                      fill_en,
  input  logic [BLK_W-1:0]          fill_blk,
  input  logic [SLOTS-1:0]          fill_map,
  input  logic [NUM_W-1:0]          fill_num,
  input  logic [FILL_BR*OFF_W-1:0]  fill_off,
  input  logic [FILL_BR*KIND_W-1:0] fill_kind,
  input  logic [FILL_BR*WA_W-1:0]   fill_tgt,
  input  logic                      evict_en,
  input  logic [BLK_W-1:0]          evict_blk,
  output logic                      lk_vld,
  output logic                      lk_hit,
  output logic [KIND_W-1:0]         lk_kind,
  output logic [WA_W-1:0]           lk_target,
  output logic [WA_W-1:0]           lk_next
);
  // fill slices
  br_ent_t fill_ents [BR_PER_BUNDLE];
  logic    ovf_wr;

  for (genvar g = 0; g < BR_PER_BUNDLE; g++) begin : g_slice
    assign fill_ents[g] = {(NUM_W'(g) < fill_num),
                           fill_off [g*OFF_W  +: OFF_W],
                           fill_kind[g*KIND_W +: KIND_W],
                           fill_tgt [g*WA_W   +: WA_W]};
  end

  assign ovf_wr = fill_en && (fill_num == NUM_W'(FILL_BR));

  // lookup address split
  logic [BLK_W-1:0] lk_blk;
  logic [OFF_W-1:0] lk_off;
  assign lk_blk = lk_word[WA_W-1:OFF_W];
  assign lk_off = lk_word[OFF_W-1:0];

  logic             rd_present;
  logic [SLOTS-1:0] rd_map;
  br_ent_t          rd_ents [BR_PER_BUNDLE];

  bbtb_bundle_array #(.NB(NUM_BUNDLES), .ENT(BR_PER_BUNDLE)) u_bundles (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_en),
    .fill_blk   (fill_blk),
    .fill_map   (fill_map),
    .fill_ents  (fill_ents),
    .evict_en   (evict_en),
    .evict_blk  (evict_blk),
    .rd_blk     (lk_blk),
    .rd_present (rd_present),
    .rd_map     (rd_map),
    .rd_ents    (rd_ents)
  );

  // next-branch scan
  logic [SLOTS-1:0] scan_map;
  logic [OFF_W:0]   pick;
  logic             pick_found;
  logic [OFF_W-1:0] pick_off;

  assign scan_map   = rd_present ? (rd_map & slots_from(lk_off)) : '0;
  assign pick       = first_set(scan_map);
  assign pick_found = pick[OFF_W];
  assign pick_off   = pick[OFF_W-1:0];

  // bundle entry match
  logic [BR_PER_BUNDLE-1:0] ent_hit_vec;
  logic [KIND_W-1:0]        bnd_kind;
  logic [WA_W-1:0]          bnd_tgt;

  for (genvar g = 0; g < BR_PER_BUNDLE; g++) begin : g_match
    assign ent_hit_vec[g] = pick_found && rd_ents[g].vld && (rd_ents[g].off == pick_off);
  end

  always_comb begin
    bnd_kind = '0;
    bnd_tgt  = '0;
    for (int g = 0; g < BR_PER_BUNDLE; g++) begin
      if (ent_hit_vec[g]) begin
        bnd_kind = rd_ents[g].kind;
        bnd_tgt  = rd_ents[g].tgt;
      end
    end
  end

  // overflow store
  logic                 ovf_hit_raw;
  logic [KIND_W-1:0]    ovf_kind;
  logic [WA_W-1:0]      ovf_tgt;
  logic [OVF_DEPTH-1:0] ovf_hit_vec;
  logic [PTR_W-1:0]     ovf_ptr;

  bbtb_overflow #(.DEPTH(OVF_DEPTH)) u_overflow (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ovf_wr),
    .wr_blk     (fill_blk),
    .wr_off     (fill_off [BR_PER_BUNDLE*OFF_W  +: OFF_W]),
    .wr_kind    (fill_kind[BR_PER_BUNDLE*KIND_W +: KIND_W]),
    .wr_tgt     (fill_tgt [BR_PER_BUNDLE*WA_W   +: WA_W]),
    .kill_a_en  (fill_en),
    .kill_a_blk (fill_blk),
    .kill_b_en  (evict_en),
    .kill_b_blk (evict_blk),
    .rd_blk     (lk_blk),
    .rd_off     (pick_off),
    .rd_hit     (ovf_hit_raw),
    .rd_kind    (ovf_kind),
    .rd_tgt     (ovf_tgt),
    .hit_vec    (ovf_hit_vec),
    .ptr        (ovf_ptr)
  );

  // result, bundle first then overflow
  logic              bnd_hit, res_hit;
  logic [KIND_W-1:0] res_kind;
  logic [WA_W-1:0]   res_tgt;

  assign bnd_hit  = |ent_hit_vec;
  assign res_hit  = bnd_hit || (pick_found && ovf_hit_raw);
  assign res_kind = bnd_hit ? bnd_kind : ovf_kind;
  assign res_tgt  = bnd_hit ? bnd_tgt  : ovf_tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_vld    <= 1'b0;
      lk_hit    <= 1'b0;
      lk_kind   <= '0;
      lk_target <= '0;
      lk_next   <= '0;
    end else begin
      lk_vld <= lk_en;
      if (lk_en) begin
        lk_hit    <= res_hit;
        lk_kind   <= res_hit ? res_kind : '0;
        lk_target <= res_hit ? res_tgt  : '0;
        lk_next   <= res_hit ? res_tgt  : next_block_word(lk_blk);
      end
    end
  end
endmodule

// File: rtl/bundle_btb_chk.sv
module bundle_btb_chk
  import bbtb_pkg::*;
#(
  parameter int ENT   = 3,
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH)
)(
  input logic              clk,
  input logic              rst_n,
  input logic              lk_en,
  input logic              lk_vld,
  input logic              lk_hit,
  input logic [KIND_W-1:0] lk_kind,
  input logic [WA_W-1:0]   lk_target,
  input logic [WA_W-1:0]   lk_next,
  input logic [ENT-1:0]    ent_hit_vec,
  input logic [DEPTH-1:0]  ovf_hit_vec,
  input logic              ovf_wr,
  input logic [PTR_W-1:0]  ovf_ptr
);
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |=> lk_vld);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> !lk_vld);

  a_r3_next_is_target: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_vld && lk_hit) |-> (lk_next == lk_target));

  a_r4_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_vld && !lk_hit) |-> (lk_kind == '0 && lk_target == '0 && lk_next[OFF_W-1:0] == '0));

  a_r5_one_ovf_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ovf_hit_vec));

  a_r5_one_bundle_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ent_hit_vec));

  a_r5_sources_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    !((|ent_hit_vec) && (|ovf_hit_vec)));

  a_r8_round_robin: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_wr |=> (ovf_ptr == (($past(ovf_ptr) == PTR_W'(DEPTH - 1)) ? '0 : $past(ovf_ptr) + PTR_W'(1))));
endmodule

bind bundle_btb bundle_btb_chk #(.ENT(BR_PER_BUNDLE), .DEPTH(OVF_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_en       (lk_en),
  .lk_vld      (lk_vld),
  .lk_hit      (lk_hit),
  .lk_kind     (lk_kind),
  .lk_target   (lk_target),
  .lk_next     (lk_next),
  .ent_hit_vec (ent_hit_vec),
  .ovf_hit_vec (ovf_hit_vec),
  .ovf_wr      (ovf_wr),
  .ovf_ptr     (ovf_ptr)
);

// File: tb/bundle_btb_test.sv
`timescale 1ns/100ps
module bundle_btb_test;
  localparam int NB = 16;
  localparam int ENT = 3;
  localparam int OD = 32;
  localparam int FB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_en = 1'b0;
  logic [29:0] lk_word = '0;
  logic fill_en = 1'b0;
  logic [25:0] fill_blk = '0;
  logic [15:0] fill_map = '0;
  logic [2:0] fill_num = '0;
  logic [FB*4-1:0] fill_off = '0;
  logic [FB*2-1:0] fill_kind = '0;
  logic [FB*30-1:0] fill_tgt = '0;
  logic evict_en = 1'b0;
  logic [25:0] evict_blk = '0;
  logic lk_vld, lk_hit;
  logic [1:0] lk_kind;
  logic [29:0] lk_target, lk_next;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bundle_btb #(.NUM_BUNDLES(NB), .BR_PER_BUNDLE(ENT), .OVF_DEPTH(OD)) uut (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_word(lk_word),
    .fill_en(fill_en), .fill_blk(fill_blk), .fill_map(fill_map), .fill_num(fill_num),
    .fill_off(fill_off), .fill_kind(fill_kind), .fill_tgt(fill_tgt),
    .evict_en(evict_en), .evict_blk(evict_blk),
    .lk_vld(lk_vld), .lk_hit(lk_hit), .lk_kind(lk_kind),
    .lk_target(lk_target), .lk_next(lk_next)
  );

  // behavioural reference
  bit          m_v  [NB];
  logic [25:0] m_b  [NB];
  logic [15:0] m_bm [NB];
  bit          m_ev [NB][ENT];
  logic [3:0]  m_eo [NB][ENT];
  logic [1:0]  m_ek [NB][ENT];
  logic [29:0] m_et [NB][ENT];
  bit          o_v [OD];
  logic [25:0] o_b [OD];
  logic [3:0]  o_o [OD];
  logic [1:0]  o_k [OD];
  logic [29:0] o_t [OD];
  int          o_p;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_look(input logic [29:0] w, output bit h, output logic [1:0] k,
                            output logic [29:0] t, output logic [29:0] n);
    int ix, first;
    bit f;
    logic [25:0] b;
    b = w[29:4];
    ix = int'(b % NB);
    h = 0; k = 0; t = 0; f = 0;
    n = {b + 26'd1, 4'd0};
    first = -1;
    if (m_v[ix] && m_b[ix] == b)
      for (int s = int'(w[3:0]); s < 16; s++)
        if (m_bm[ix][s] && first < 0) first = s;
    if (first >= 0) begin
      for (int g = 0; g < ENT; g++)
        if (!f && m_ev[ix][g] && int'(m_eo[ix][g]) == first) begin
          f = 1; k = m_ek[ix][g]; t = m_et[ix][g];
        end
      for (int j = 0; j < OD; j++)
        if (!f && o_v[j] && o_b[j] == b && int'(o_o[j]) == first) begin
          f = 1; k = o_k[j]; t = o_t[j];
        end
      if (f) begin h = 1; n = t; end
    end
  endtask

  task automatic model_write();
    int fi, ei;
    fi = int'(fill_blk % NB);
    ei = int'(evict_blk % NB);
    if (evict_en && m_v[ei] && m_b[ei] == evict_blk && !(fill_en && fi == ei)) m_v[ei] = 0;
    for (int j = 0; j < OD; j++)
      if ((fill_en && o_b[j] == fill_blk) || (evict_en && o_b[j] == evict_blk)) o_v[j] = 0;
    if (fill_en) begin
      m_v[fi] = 1; m_b[fi] = fill_blk; m_bm[fi] = fill_map;
      for (int g = 0; g < ENT; g++) begin
        m_ev[fi][g] = (g < int'(fill_num));
        m_eo[fi][g] = fill_off[g*4 +: 4];
        m_ek[fi][g] = fill_kind[g*2 +: 2];
        m_et[fi][g] = fill_tgt[g*30 +: 30];
      end
      if (int'(fill_num) == FB) begin
        o_v[o_p] = 1; o_b[o_p] = fill_blk;
        o_o[o_p] = fill_off[ENT*4 +: 4];
        o_k[o_p] = fill_kind[ENT*2 +: 2];
        o_t[o_p] = fill_tgt[ENT*30 +: 30];
        o_p = (o_p + 1) % OD;
      end
    end
  endtask

  // one clock: predict, advance model, compare after the edge
  task automatic cyc(input string tag);
    bit nv, h;
    logic [1:0] k;
    logic [29:0] t, n;
    nv = lk_en;
    h = 0; k = 0; t = 0; n = 0;
    if (nv) model_look(lk_word, h, k, t, n);
    model_write();
    @(posedge clk);
    @(negedge clk);
    check(lk_vld === nv, "R2", {tag, " lk_vld"}, 64'(lk_vld), 64'(nv));
    if (nv) begin
      check(lk_hit === h, tag, "model hit", 64'(lk_hit), 64'(h));
      check(lk_kind === k, tag, "model kind", 64'(lk_kind), 64'(k));
      check(lk_target === t, tag, "model target", 64'(lk_target), 64'(t));
      check(lk_next === n, tag, "model next", 64'(lk_next), 64'(n));
    end
  endtask

  task automatic look(input logic [29:0] w, input bit eh, input logic [1:0] ek,
                      input logic [29:0] en, input string tag);
    lk_en = 1; lk_word = w;
    cyc(tag);
    lk_en = 0;
    check(lk_hit === eh, tag, "hit", 64'(lk_hit), 64'(eh));
    check(lk_kind === (eh ? ek : 2'd0), tag, "kind", 64'(lk_kind), 64'(eh ? ek : 2'd0));
    check(lk_next === en, tag, "next", 64'(lk_next), 64'(en));
  endtask

  task automatic set_fill(input logic [25:0] b, input logic [15:0] bm, input logic [2:0] num,
                          input logic [15:0] offs, input logic [7:0] kinds, input logic [119:0] tgts);
    fill_en = 1; fill_blk = b; fill_map = bm; fill_num = num;
    fill_off = offs; fill_kind = kinds; fill_tgt = tgts;
  endtask

  task automatic do_fill(input logic [25:0] b, input logic [15:0] bm, input logic [2:0] num,
                         input logic [15:0] offs, input logic [7:0] kinds, input logic [119:0] tgts,
                         input string tag);
    set_fill(b, bm, num, offs, kinds, tgts);
    cyc(tag);
    fill_en = 0;
  endtask

  initial begin : watchdog
    #500000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < NB; i++) m_v[i] = 0;
    for (int j = 0; j < OD; j++) begin o_v[j] = 0; o_b[j] = '0; end
    o_p = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(lk_vld === 1'b0, "R1", "lk_vld in reset", 64'(lk_vld), 64'd0);
    check(lk_hit === 1'b0, "R1", "lk_hit in reset", 64'(lk_hit), 64'd0);
    rst_n = 1;
    look(30'h400, 0, 0, 30'h410, "R1");

    // dense block 0x40: slots 3,7,9,12, fourth branch spills (R5)
    do_fill(26'h40, 16'h1288, 3'd4, 16'hC973, 8'h39,
            {30'h400, 30'h300, 30'h200, 30'h100}, "R5");
    look(30'h400, 1, 2'd1, 30'h100, "R3");
    look(30'h404, 1, 2'd2, 30'h200, "R3");
    look(30'h409, 1, 2'd3, 30'h300, "R3");
    look(30'h40A, 1, 2'd0, 30'h400, "R5");
    look(30'h40D, 0, 0, 30'h410, "R4");
    // alias at index 0 (R9)
    look(30'h500, 0, 0, 30'h510, "R9");

    // R12 lookup in the cycle of its own fill sees old state
    set_fill(26'h41, 16'h0001, 3'd1, 16'h0000, 8'h02, {90'h0, 30'h777});
    lk_en = 1; lk_word = 30'h410;
    cyc("R12");
    fill_en = 0; lk_en = 0;
    check(lk_hit === 1'b0, "R12", "hit same cycle", 64'(lk_hit), 64'd0);
    check(lk_next === 30'h420, "R12", "next same cycle", 64'(lk_next), 64'h420);
    look(30'h410, 1, 2'd2, 30'h777, "R12");

    // R6 refill drops old bundle and overflow content
    do_fill(26'h40, 16'h0020, 3'd1, 16'h0005, 8'h02, {90'h0, 30'h55}, "R6");
    look(30'h40A, 0, 0, 30'h410, "R6");
    look(30'h400, 1, 2'd2, 30'h55, "R6");

    // R10 marked slot without entry
    do_fill(26'h42, 16'h0004, 3'd0, 16'h0000, 8'h00, 120'h0, "R10");
    look(30'h420, 0, 0, 30'h430, "R10");

    // R11 fill and evict on the same index
    set_fill(26'h41, 16'h0001, 3'd1, 16'h0000, 8'h02, {90'h0, 30'h777});
    evict_en = 1; evict_blk = 26'h41;
    cyc("R11");
    fill_en = 0; evict_en = 0;
    look(30'h410, 1, 2'd2, 30'h777, "R11");

    // R7 eviction
    evict_en = 1; evict_blk = 26'h40;
    cyc("R7");
    evict_en = 0;
    look(30'h400, 0, 0, 30'h410, "R7");

    // R8 round robin lifetime of one overflow entry
    do_fill(26'h43, 16'h001E, 3'd4, 16'h4321, 8'h55,
            {30'h999, 30'h333, 30'h222, 30'h111}, "R8");
    look(30'h434, 1, 2'd1, 30'h999, "R5");
    for (int k = 0; k < OD - 1; k++)
      do_fill(26'h45 + 26'(k * 16), 16'h001E, 3'd4, 16'h4321, 8'h00,
              {30'h1, 30'h2, 30'h3, 30'h4}, "R8");
    look(30'h434, 1, 2'd1, 30'h999, "R8");
    do_fill(26'h45 + 26'((OD - 1) * 16), 16'h001E, 3'd4, 16'h4321, 8'h00,
            {30'h1, 30'h2, 30'h3, 30'h4}, "R8");
    look(30'h434, 0, 0, 30'h440, "R8");
    look(30'h433, 1, 2'd1, 30'h333, "R8");

    // mixed traffic against the reference
    for (int c = 0; c < 3000; c++) begin
      int cnt;
      lk_en = ($urandom % 10) < 7;
      lk_word = {26'h60 + 26'($urandom % 40), 4'($urandom)};
      fill_en = ($urandom % 5) == 0;
      fill_blk = 26'h60 + 26'($urandom % 40);
      fill_map = 16'($urandom) & 16'($urandom);
      cnt = 0;
      fill_off = '0; fill_kind = '0; fill_tgt = '0;
      for (int s = 0; s < 16; s++)
        if (fill_map[s] && cnt < FB) begin
          fill_off[cnt*4 +: 4] = 4'(s);
          fill_kind[cnt*2 +: 2] = 2'($urandom);
          fill_tgt[cnt*30 +: 30] = 30'($urandom);
          cnt++;
        end
      if (cnt > 0 && ($urandom % 8) == 0) cnt--;
      fill_num = 3'(cnt);
      evict_en = ($urandom % 10) == 0;
      evict_blk = 26'h60 + 26'($urandom % 40);
      cyc("R3");
    end
    lk_en = 0; fill_en = 0; evict_en = 0;
    cyc("R2");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule